// File: doc/BRIEF.md
# PCI Interrupt Router with Trigger Control

This block connects four active-low PCI interrupt pins to a 16-line set of legacy interrupt request lines. Two 8-bit configuration registers select where each pin goes. Each register holds two 4-bit routing fields, one per pin. In each field, a 3-bit selector picks the destination line from a small fixed set, and a trigger bit chooses how the pin is presented on that line:

- **Level mode.** The request line follows the pin.
- **Edge mode.** The level interrupt is converted into a single-cycle pulse each time the pin becomes active.

Besides the request lines, the block reports two things:

- a 16-bit mask of the request lines currently served in edge mode;
- a per-pin flag showing whether that pin is routed anywhere.

Software writes the two registers through a simple byte-wide write port and can read them back. All outputs are registered.

Top module: `pirq_router`

## Requirements
- R1: After a synchronous reset:
  - the first routing register (address 0x80) reads 0x80 and the second (address 0x81) reads 0x00;
  - `irq_req`, `edge_mask` and `pin_routed` are all zero.
- R2: Field positions are fixed:
  - pin 0 is controlled by bits 3:0 of address 0x80 and pin 1 by bits 7:4 of address 0x80;
  - pin 2 is controlled by bits 3:0 of address 0x81 and pin 3 by bits 7:4 of address 0x81.
- R3: Bits 2:0 of a field select the destination line:

  | Selector code | Destination |
  |---|---|
  | 0 | none |
  | 1 | line 5 |
  | 2 | line 9 |
  | 3 | line 10 |
  | 4 | line 11 |
  | 5 | line 12 |
  | 6 | line 14 |
  | 7 | line 15 |

  No other line is ever driven.
- R4: A field with selector code 0 has no effect, whatever its bit 3:
  - its pin is not routed (`pin_routed` bit clear);
  - the pin drives no request line;
  - the field adds nothing to `edge_mask`.
- R5: With bit 3 of a field clear (level mode), the destination line is high for as long as the pin is low, delayed by two clock edges.
- R6: With bit 3 of a field set (edge mode), each high-to-low transition of the pin produces exactly one high cycle on the destination line. A pin held low produces no further pulses.
- R7: `edge_mask` has a bit set exactly for the destination lines of routed fields whose bit 3 is set. Rewriting a register removes the mask bits of its old fields.
- R8: When several pins share a destination line, the line is the OR of their individual requests, including a mix of level and edge pins.
- R9: Reads and writes follow these rules:
  - `cfg_rdata` shows, one clock after `cfg_addr` is presented, the stored value of the addressed routing register;
  - other addresses read 0x00;
  - writes to other addresses change nothing.
- R10: A routing write accepted at clock edge N changes `irq_req`, `edge_mask` and `pin_routed` at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the routing registers |
| cfg_addr | input | 8 | Register address (write and read) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| pci_int_n | input | 4 | Active-low PCI interrupt pins 0..3 |
| irq_req | output | 16 | Legacy interrupt request lines |
| edge_mask | output | 16 | Lines currently fed in edge mode |
| pin_routed | output | 4 | Per-pin routed flag |

## Verification
A table walks every selector code on a single active pin, so that each code is told apart by the one line it lights. Further table rows exercise the following patterns:

| Pattern | What it tells apart |
|---|---|
| One pin active while its neighbour's field is also set | Field position within a register |
| All four pins active | All four pins decoded at once |
| Several pins sharing one line | The OR merge on a shared line |
| Code 0 with the trigger bit set | A disabled field from a routed one |

Directed sequences then separate a held level request from a single edge pulse. They also separate re-assertion after release from a held pin, and mixed level and edge sharing of a line. Finally they check the one-clock output latency after a write, mask clean-up on rewrite, and reads and writes at an unmapped address.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int FIELD_W = 4;
  localparam int SEL_W   = 3;
  localparam int LINE_W  = 5;

  // Sparse selector: code -> legacy line number (0 means not routed)
  function automatic logic [LINE_W-1:0] sel_line(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return 5'd5;
      3'd2:    return 5'd9;
      3'd3:    return 5'd10;
      3'd4:    return 5'd11;
      3'd5:    return 5'd12;
      3'd6:    return 5'd14;
      3'd7:    return 5'd15;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80,
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL = 16'h0080
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NUM_REGS*DATA_W-1:0]   reg_flat,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] reg_q [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign hit[r] = (addr == BASE_ADDR + ADDR_W'(r));
    always_ff @(posedge clk) begin
      if (rst)               reg_q[r] <= RST_VAL[r*DATA_W +: DATA_W];
      else if (wr && hit[r]) reg_q[r] <= wdata;
    end
    assign reg_flat[r*DATA_W +: DATA_W] = reg_q[r];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      rdata <= '0;
      for (int r = 0; r < NUM_REGS; r++)
        if (hit[r]) rdata <= reg_q[r];
    end
  end
endmodule

// File: rtl/pirq_field_dec.sv
module pirq_field_dec
  import pirq_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic [FIELD_W-1:0] field,
  output logic [NUM_IRQ-1:0] line_oh,
  output logic               routed,
  output logic               edge_en
);
  logic [LINE_W-1:0] ln;

  always_comb begin
    ln      = sel_line(field[SEL_W-1:0]);
    routed  = (field[SEL_W-1:0] != '0);
    edge_en = routed & field[FIELD_W-1];
    for (int i = 0; i < NUM_IRQ; i++)
      line_oh[i] = routed && (ln == LINE_W'(i));
  end
endmodule

// File: rtl/pirq_pin_cond.sv
module pirq_pin_cond (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic active,
  output logic rise
);
  logic act_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      act_q  <= ~pin_n;
      prev_q <= act_q;
    end
  end

  assign active = act_q;
  assign rise   = act_q & ~prev_q;
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int NUM_IRQ  = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80,
  parameter logic [NUM_PINS*FIELD_W-1:0] RST_VAL = 16'h0080
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic [NUM_PINS-1:0] pci_int_n,
  output logic [NUM_IRQ-1:0]  irq_req,
  output logic [NUM_IRQ-1:0]  edge_mask,
  output logic [NUM_PINS-1:0] pin_routed
);
  localparam int PINS_PER_REG = DATA_W / FIELD_W;
  localparam int NUM_REGS     = NUM_PINS / PINS_PER_REG;

  logic [NUM_REGS*DATA_W-1:0] reg_flat;
  logic [NUM_IRQ-1:0]  oh [NUM_PINS];
  logic [NUM_PINS-1:0] routed_c, edge_c, act_c, rise_c;
  logic [NUM_IRQ-1:0]  req_n, mask_n;

  pirq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .BASE_ADDR(BASE_ADDR), .RST_VAL(RST_VAL)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .reg_flat(reg_flat), .rdata(cfg_rdata)
  );

  // Fields are packed in pin order, so pin p sits at bit p*FIELD_W
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pirq_field_dec #(.NUM_IRQ(NUM_IRQ)) u_dec (
      .field(reg_flat[p*FIELD_W +: FIELD_W]),
      .line_oh(oh[p]), .routed(routed_c[p]), .edge_en(edge_c[p])
    );
    pirq_pin_cond u_cond (
      .clk(clk), .rst(rst), .pin_n(pci_int_n[p]),
      .active(act_c[p]), .rise(rise_c[p])
    );
  end

  always_comb begin
    req_n  = '0;
    mask_n = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (edge_c[p]) begin
        mask_n |= oh[p];
        if (rise_c[p]) req_n |= oh[p];
      end else if (act_c[p]) begin
        req_n |= oh[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req    <= '0;
      edge_mask  <= '0;
      pin_routed <= '0;
    end else begin
      irq_req    <= req_n;
      edge_mask  <= mask_n;
      pin_routed <= routed_c;
    end
  end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int NUM_IRQ  = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int REG_BITS = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   cfg_addr,
  input logic [DATA_W-1:0]   cfg_rdata,
  input logic [NUM_IRQ-1:0]  irq_req,
  input logic [NUM_IRQ-1:0]  edge_mask,
  input logic [NUM_PINS-1:0] pin_routed,
  input logic [REG_BITS-1:0] reg_flat
);
  logic [NUM_IRQ-1:0] legal;
  always_comb begin
    legal = '0;
    for (int c = 1; c < 8; c++)
      for (int i = 0; i < NUM_IRQ; i++)
        if (sel_line(SEL_W'(c)) == LINE_W'(i)) legal[i] = 1'b1;
  end

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_req == '0 && edge_mask == '0 && pin_routed == '0 && cfg_rdata == '0));

  a_r3_legal_lines: assert property (@(posedge clk) disable iff (rst)
    ((irq_req | edge_mask) & ~legal) == '0);

  a_r4_unrouted_silent: assert property (@(posedge clk) disable iff (rst)
    (pin_routed == '0) |-> (irq_req == '0 && edge_mask == '0));

  a_r7_mask_within_routed: assert property (@(posedge clk) disable iff (rst)
    $countones(edge_mask) <= $countones(pin_routed));

  a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == BASE_ADDR) |=> (cfg_rdata == $past(reg_flat[DATA_W-1:0])));
endmodule

bind pirq_router pirq_router_chk #(
  .NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .REG_BITS(NUM_REGS*DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .irq_req(irq_req), .edge_mask(edge_mask), .pin_routed(pin_routed),
  .reg_flat(reg_flat)
);

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [3:0]  pci_int_n = 4'hF;
  logic [15:0] irq_req, edge_mask;
  logic [3:0]  pin_routed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pirq_router u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pci_int_n(pci_int_n),
    .irq_req(irq_req), .edge_mask(edge_mask), .pin_routed(pin_routed)
  );

  // {reg0, reg1, pins_n, exp irq, exp mask, exp routed}
  localparam int NV = 13;
  localparam logic [55:0] VEC [NV] = '{
    {8'h80, 8'h00, 4'b1110, 16'h0000, 16'h0000, 4'b0000},
    {8'h01, 8'h00, 4'b1110, 16'h0020, 16'h0000, 4'b0001},
    {8'h20, 8'h00, 4'b1101, 16'h0200, 16'h0000, 4'b0010},
    {8'h00, 8'h03, 4'b1011, 16'h0400, 16'h0000, 4'b0100},
    {8'h00, 8'h40, 4'b0111, 16'h0800, 16'h0000, 4'b1000},
    {8'h05, 8'h00, 4'b1110, 16'h1000, 16'h0000, 4'b0001},
    {8'h60, 8'h00, 4'b1101, 16'h4000, 16'h0000, 4'b0010},
    {8'h00, 8'h70, 4'b0111, 16'h8000, 16'h0000, 4'b1000},
    {8'h0D, 8'h00, 4'b1110, 16'h1000, 16'h1000, 4'b0001},
    {8'h11, 8'h11, 4'b1011, 16'h0020, 16'h0000, 4'b1111},
    {8'h32, 8'h54, 4'b0000, 16'h1E00, 16'h0000, 4'b1111},
    {8'h98, 8'h00, 4'b1111, 16'h0000, 16'h0020, 4'b0010},
    {8'h21, 8'h00, 4'b1101, 16'h0200, 16'h0000, 4'b0011}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 11:  return "R4";
      8:      return "R7";
      9:      return "R8";
      10, 12: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "irq", 32'(irq_req), 32'h0);
    chk("R1", "mask", 32'(edge_mask), 32'h0);
    chk("R1", "routed", 32'(pin_routed), 32'h0);
    rd(8'h80, d); chk("R1", "reg80", 32'(d), 32'h80);
    rd(8'h81, d); chk("R1", "reg81", 32'(d), 32'h00);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      pci_int_n = 4'hF;
      wr(8'h80, VEC[i][55:48]);
      wr(8'h81, VEC[i][47:40]);
      step(1);
      pci_int_n = VEC[i][39:36];
      step(2);
      chk(row_tag(i), "irq", 32'(irq_req), 32'(VEC[i][35:20]));
      chk(row_tag(i), "mask", 32'(edge_mask), 32'(VEC[i][19:4]));
      chk(row_tag(i), "routed", 32'(pin_routed), 32'(VEC[i][3:0]));
    end

    // R10 write latency with pin already active
    pci_int_n = 4'hF; wr(8'h81, 8'h00); wr(8'h80, 8'h00);
    pci_int_n = 4'b1110; step(3);
    wr(8'h80, 8'h01);
    chk("R10", "irq before", 32'(irq_req), 32'h0);
    step(1);
    chk("R10", "irq after", 32'(irq_req), 32'h0020);

    // R5 level hold and release
    step(4);
    chk("R5", "irq held", 32'(irq_req), 32'h0020);
    pci_int_n = 4'hF;
    step(1);
    chk("R5", "irq release lag", 32'(irq_req), 32'h0020);
    step(1);
    chk("R5", "irq released", 32'(irq_req), 32'h0);

    // R6 edge pulse
    wr(8'h80, 8'h09); step(3);
    pci_int_n = 4'b1110; step(2);
    chk("R6", "pulse", 32'(irq_req), 32'h0020);
    step(1);
    chk("R6", "pulse end", 32'(irq_req), 32'h0);
    step(3);
    chk("R6", "held no repeat", 32'(irq_req), 32'h0);
    pci_int_n = 4'hF; step(3);
    pci_int_n = 4'b1110; step(2);
    chk("R6", "second pulse", 32'(irq_req), 32'h0020);

    // R7 mask on rewrite
    pci_int_n = 4'hF;
    wr(8'h81, 8'h0E); wr(8'h80, 8'hBC); step(1);
    chk("R7", "mask both", 32'(edge_mask), 32'h4C00);
    wr(8'h80, 8'h01); step(1);
    chk("R7", "mask rewritten", 32'(edge_mask), 32'h4000);
    chk("R7", "routed", 32'(pin_routed), 32'h5);

    // R8 mixed level and edge on one line
    wr(8'h81, 8'h00); wr(8'h80, 8'h91); step(3);
    pci_int_n = 4'b1101; step(2);
    chk("R8", "edge share pulse", 32'(irq_req), 32'h0020);
    step(1);
    chk("R8", "edge share end", 32'(irq_req), 32'h0);
    pci_int_n = 4'b1100; step(2);
    chk("R8", "level joins", 32'(irq_req), 32'h0020);
    step(3);
    chk("R8", "level holds", 32'(irq_req), 32'h0020);
    pci_int_n = 4'hF;

    // R9 readback and unmapped address
    wr(8'h80, 8'hA5);
    rd(8'h80, d); chk("R9", "read80", 32'(d), 32'hA5);
    rd(8'h81, d); chk("R9", "read81", 32'(d), 32'h00);
    wr(8'h82, 8'hFF);
    rd(8'h80, d); chk("R9", "read80 after stray", 32'(d), 32'hA5);
    rd(8'h81, d); chk("R9", "read81 after stray", 32'(d), 32'h00);
    rd(8'h82, d); chk("R9", "read unmapped", 32'(d), 32'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule